// File: doc/BRIEF.md
# Two-Level Interrupt Priority Controller

This block arbitrates the interrupt requests of a small 8-bit processor core. Five request sources come in: two active-low external pins, two timer overflow flags and one serial flag formed from a receive flag and a transmit flag. A per-source enable mask, a global enable and a per-source level bit (high or low) qualify them. The block selects one winner and presents its vector address to the CPU. It also keeps a two-bit record of which priority levels are currently being serviced, so that a high-level request can interrupt a low-level handler but never the other way round.

The request to the CPU is a valid/ready style handshake. `irq_req` acts as valid and `irq_vector` as its payload. `irq_ack` acts as ready, and a transfer happens in a cycle where both are high. Nothing needs to be held back: while `irq_req` is high and unacknowledged, the vector may change if a stronger request shows up. The CPU takes whatever vector is shown in the cycle it acknowledges, and `irq_ack` has no effect while `irq_req` is low. `irq_reti` is a plain strobe that marks the end of the innermost handler.

Each external pin passes through a two-flop synchronizer. It can then be used either as a level request that follows the pin or as a falling-edge request that is latched until its vector is acknowledged.

Top module: `irq_prio_ctrl`

## Requirements
- R1: The serial source is pending when `ser_rx_flag` or `ser_tx_flag` is high. The timer sources are pending while `tmr_ovf[0]` or `tmr_ovf[1]` is high.
- R2: A source competes only when its bit in `src_en` is set and `glob_en` is high. With `glob_en` low, `irq_req` stays low.
- R3: Any eligible source whose `src_hi` bit is set wins over every eligible source whose bit is clear, whatever their polling positions.
- R4: Ties within one level go to the lowest polling index: ext0=0, tmr0=1, ext1=2, tmr1=3, serial=4 (this is also the bit index in `src_en`/`src_hi`). The vector is 0x0003 + 8*index, giving 0003, 000B, 0013, 001B, 0023.
- R5: With `ext_edge_mode[i]`=0, a low pin raises its request two clock edges after it is driven. The request drops two edges after the pin returns high, so nothing is latched.
- R6: With `ext_edge_mode[i]`=1, a high-to-low pin transition raises a latched request three edges after the pin is driven low. The request stays pending after the pin rises and is cleared by the acknowledge of that source's vector.
- R7: While a low-level handler is in service, an eligible high-level request raises `irq_req`, but a low-level request does not.
- R8: While a high-level handler is in service, `irq_req` stays low.
- R9: `irq_reti` clears the innermost in-service level (high before low), so pending requests that were blocked become visible again the next cycle.
- R10: After reset, `irq_req` is low and no level is in service.
- R11: A transfer happens only when `irq_req` and `irq_ack` are both high. An `irq_ack` while `irq_req` is low changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_pin_n | input | 2 | External request pins, active low (bit0 ext0, bit1 ext1) |
| ext_edge_mode | input | 2 | 1 = falling-edge latched, 0 = low level, per pin |
| tmr_ovf | input | 2 | Timer overflow flags (bit0 tmr0, bit1 tmr1) |
| ser_rx_flag | input | 1 | Serial receive flag |
| ser_tx_flag | input | 1 | Serial transmit flag |
| src_en | input | 5 | Per-source enable, indexed by polling order |
| src_hi | input | 5 | Per-source high-level bit, indexed by polling order |
| glob_en | input | 1 | Global interrupt enable |
| irq_req | output | 1 | Request valid toward CPU |
| irq_vector | output | 16 | Vector of current winner |
| irq_ack | input | 1 | CPU accepts the shown vector |
| irq_reti | input | 1 | Return-from-interrupt strobe |

## Verification
Arbitration is swept over all 32x32x32 combinations of pending set, enable mask and level mask, and each result is compared with a reference model. This separates errors in level ordering from errors in polling order and enable gating. The serial source is driven alternately by its receive and transmit flags. Directed sequences on the external pins measure the two-edge and three-edge latencies and show that the level mode does not latch while the edge mode holds until acknowledge. A nested acknowledge/return sequence then shows which requests may preempt each in-service state and that a stray acknowledge leaves that state alone.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC       = 5;
  localparam int NEXT       = 2;
  localparam int IDX_W      = $clog2(NSRC);
  localparam int VEC_W      = 16;
  localparam int VEC_BASE   = 3;
  localparam int VEC_STRIDE = 8;

  // polling index of external pin i (ext0 -> 0, ext1 -> 2)
  function automatic logic [IDX_W-1:0] ext_slot(input int i);
    return IDX_W'(2 * i);
  endfunction

  function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] idx);
    return VEC_W'(VEC_BASE + VEC_STRIDE * int'(idx));
  endfunction
endpackage

// File: rtl/irq_ext_detect.sv
module irq_ext_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  input  logic edge_mode,
  input  logic clr,
  output logic req
);
  logic [SYNC_STAGES-1:0] sh;
  logic                   prev;
  logic                   flag;
  logic                   synced;
  logic                   fall;

  assign synced = sh[SYNC_STAGES-1];
  assign fall   = prev & ~synced;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '1;
      prev <= 1'b1;
      flag <= 1'b0;
    end else begin
      sh   <= {sh[SYNC_STAGES-2:0], pin_n};
      prev <= synced;
      if (!edge_mode) flag <= 1'b0;
      else            flag <= (flag & ~clr) | fall;
    end
  end

  assign req = edge_mode ? flag : ~synced;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
(
  input  logic [NSRC-1:0]  pend,
  input  logic [NSRC-1:0]  en,
  input  logic [NSRC-1:0]  hi,
  input  logic             glob,
  output logic             win_any,
  output logic             win_hi,
  output logic [IDX_W-1:0] win_idx
);
  logic [NSRC-1:0] elig, elig_hi, elig_lo, pick_set;

  assign elig     = pend & en & {NSRC{glob}};
  assign elig_hi  = elig & hi;
  assign elig_lo  = elig & ~hi;
  assign win_hi   = |elig_hi;
  assign win_any  = |elig;
  assign pick_set = win_hi ? elig_hi : elig_lo;

  // scan downward so the lowest polling index is assigned last
  always_comb begin
    win_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (pick_set[i]) win_idx = IDX_W'(i);
  end
endmodule

// File: rtl/irq_nest.sv
module irq_nest (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take,
  input  logic       take_hi,
  input  logic       reti,
  output logic [1:0] svc
);
  logic [1:0] after_ret;

  always_comb begin
    after_ret = svc;
    if (reti) begin
      if (svc[1]) after_ret[1] = 1'b0;
      else        after_ret[0] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    svc <= 2'b00;
    else if (take) svc <= after_ret | (take_hi ? 2'b10 : 2'b01);
    else           svc <= after_ret;
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NEXT-1:0]  ext_pin_n,
  input  logic [NEXT-1:0]  ext_edge_mode,
  input  logic [1:0]       tmr_ovf,
  input  logic             ser_rx_flag,
  input  logic             ser_tx_flag,
  input  logic [NSRC-1:0]  src_en,
  input  logic [NSRC-1:0]  src_hi,
  input  logic             glob_en,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vector,
  input  logic             irq_ack,
  input  logic             irq_reti
);
  logic [NEXT-1:0]  ext_req;
  logic [NEXT-1:0]  ext_clr;
  logic [NSRC-1:0]  pend;
  logic             win_any, win_hi, allowed, take;
  logic [IDX_W-1:0] win_idx;
  logic [1:0]       svc_state;

  for (genvar g = 0; g < NEXT; g++) begin : g_ext
    assign ext_clr[g] = take && (win_idx == ext_slot(g));
    irq_ext_detect #(.SYNC_STAGES(2)) u_det (
      .clk(clk), .rst_n(rst_n), .pin_n(ext_pin_n[g]),
      .edge_mode(ext_edge_mode[g]), .clr(ext_clr[g]), .req(ext_req[g])
    );
  end

  assign pend = {ser_rx_flag | ser_tx_flag, tmr_ovf[1], ext_req[1],
                 tmr_ovf[0], ext_req[0]};

  irq_arbiter u_arb (
    .pend(pend), .en(src_en), .hi(src_hi), .glob(glob_en),
    .win_any(win_any), .win_hi(win_hi), .win_idx(win_idx)
  );

  assign allowed    = win_hi ? ~svc_state[1] : (svc_state == 2'b00);
  assign irq_req    = win_any & allowed;
  assign irq_vector = vec_of(win_idx);
  assign take       = irq_req & irq_ack;

  irq_nest u_nest (
    .clk(clk), .rst_n(rst_n), .take(take), .take_hi(win_hi),
    .reti(irq_reti), .svc(svc_state)
  );
endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk
  import irq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             irq_req,
  input logic [VEC_W-1:0] irq_vector,
  input logic             irq_ack,
  input logic             irq_reti,
  input logic             glob_en,
  input logic [1:0]       svc
);
  // R2
  a_r2_glob_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_en |-> !irq_req);
  // R4
  a_r4_vector_legal: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vector == 16'h0003 || irq_vector == 16'h000B ||
                 irq_vector == 16'h0013 || irq_vector == 16'h001B ||
                 irq_vector == 16'h0023));
  // R8
  a_r8_high_blocks_all: assert property (@(posedge clk) disable iff (!rst_n)
    svc[1] |-> !irq_req);
  // R9
  a_r9_reti_pops_high: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_reti && svc[1]) |=> !svc[1]);
  // R11
  a_r11_take_marks: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_ack && !irq_reti) |=> (svc != 2'b00));
  // R11
  a_r11_idle_ack_noop: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_req && irq_ack && !irq_reti) |=> $stable(svc));
endmodule

bind irq_prio_ctrl irq_prio_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_vector(irq_vector),
  .irq_ack(irq_ack), .irq_reti(irq_reti), .glob_en(glob_en), .svc(svc_state)
);

// File: tb/irq_prio_ctrl_bench.sv
`timescale 1ns/1ps
module irq_prio_ctrl_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [1:0]  ext_pin_n = 2'b11;
  logic [1:0]  ext_edge_mode = 2'b00;
  logic [1:0]  tmr_ovf = 2'b00;
  logic        ser_rx_flag = 0, ser_tx_flag = 0;
  logic [4:0]  src_en = 0, src_hi = 0;
  logic        glob_en = 0;
  logic        irq_req;
  logic [15:0] irq_vector;
  logic        irq_ack = 0, irq_reti = 0;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  irq_prio_ctrl u_irq_prio_ctrl (.*);

  task automatic tick(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input bit exp_req, input int exp_vec);
    chk(irq_req === exp_req, {req, " irq_req"}, int'(irq_req), int'(exp_req));
    if (exp_req)
      chk(irq_vector === 16'(exp_vec), {req, " vector"}, int'(irq_vector), exp_vec);
  endtask

  function automatic int ref_vec(input logic [4:0] pend, en, hi, input bit g);
    logic [4:0] el = pend & en & {5{g}};
    logic [4:0] s  = (|(el & hi)) ? (el & hi) : (el & ~hi);
    for (int i = 0; i < 5; i++) if (s[i]) return 3 + 8 * i;
    return -1;
  endfunction

  task automatic pulse_ack;
    irq_ack = 1; tick(); irq_ack = 0;
  endtask

  task automatic pulse_reti;
    irq_reti = 1; tick(); irq_reti = 0;
  endtask

  task automatic clear_inputs;
    ext_pin_n = 2'b11; tmr_ovf = 0; ser_rx_flag = 0; ser_tx_flag = 0;
    src_en = 0; src_hi = 0; ext_edge_mode = 0; glob_en = 0;
    tick(3);
  endtask

  task automatic t_reset;
    chk_out("R10 reset idle", 0, 0);
  endtask

  // R1 R2 R3 R4: every pending/enable/level combination
  task automatic t_sweep;
    glob_en = 1; ext_edge_mode = 0;
    for (int p = 0; p < 32; p++) begin
      logic [4:0] pv = 5'(p);
      ext_pin_n   = {~pv[2], ~pv[0]};
      tmr_ovf     = {pv[3], pv[1]};
      ser_rx_flag = pv[4] & ~pv[1];
      ser_tx_flag = pv[4] & pv[1];
      tick(3);
      for (int e = 0; e < 32; e++) begin
        for (int h = 0; h < 32; h++) begin
          int exp;
          src_en = 5'(e); src_hi = 5'(h);
          #0.1;
          exp = ref_vec(pv, 5'(e), 5'(h), 1'b1);
          chk_out("R1/R2/R3/R4 sweep", exp >= 0, exp);
        end
      end
    end
    glob_en = 0; src_en = 5'h1F; #0.1;
    chk_out("R2 global off", 0, 0);
    clear_inputs();
  endtask

  task automatic t_level;
    glob_en = 1; src_en = 5'h01; ext_edge_mode = 2'b00;
    ext_pin_n[0] = 0; tick();
    chk_out("R5 level not yet at 1 edge", 0, 0);
    tick();
    chk_out("R5 level seen at 2 edges", 1, 16'h0003);
    ext_pin_n[0] = 1; tick(2);
    chk_out("R5 level not latched", 0, 0);
    clear_inputs();
  endtask

  task automatic t_edge;
    glob_en = 1; src_en = 5'h04; ext_edge_mode = 2'b10;
    ext_pin_n[1] = 0; tick(2);
    chk_out("R6 edge not yet at 2 edges", 0, 0);
    tick();
    chk_out("R6 edge seen at 3 edges", 1, 16'h0013);
    ext_pin_n[1] = 1; tick(4);
    chk_out("R6 edge held after pin high", 1, 16'h0013);
    pulse_ack();
    pulse_reti();
    chk_out("R6 edge cleared by ack", 0, 0);
    clear_inputs();
  endtask

  task automatic t_nest;
    glob_en = 1; src_en = 5'h1F; src_hi = 5'b01000;
    tmr_ovf = 2'b01; tick();
    chk_out("R7 low request shown", 1, 16'h000B);
    pulse_ack();
    chk_out("R7 same level blocked", 0, 0);
    tmr_ovf = 2'b11; #0.1;
    chk_out("R7 high preempts low", 1, 16'h001B);
    pulse_ack();
    chk_out("R8 high in service blocks", 0, 0);
    pulse_reti();
    chk_out("R9 reti pops high level", 1, 16'h001B);
    tmr_ovf = 2'b01; #0.1;
    chk_out("R9 low still in service", 0, 0);
    pulse_reti();
    chk_out("R9 reti pops low level", 1, 16'h000B);
    tmr_ovf = 2'b00; #0.1;
    pulse_ack();
    tmr_ovf = 2'b01; #0.1;
    chk_out("R11 idle ack ignored", 1, 16'h000B);
    clear_inputs();
  endtask

  initial begin
    tick(2);
    rst_n = 1;
    tick();
    t_reset();
    t_level();
    t_edge();
    t_nest();
    t_sweep();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(5.0 * 190000);
    failures++; checks++;
    $display("FAIL watchdog actual=%h expected=%h", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule